// File: doc/BRIEF.md
# Flash Programming Command Sequencer

This block is a host-side controller that drives the complete rewrite of a target device's internal flash over a byte-wide command channel. A single start pulse launches the flow. The sequencer enters the offline programming mode and erases the array. It points the target's page address at a chosen start page and writes a number of 16-byte pages taken from a local page buffer. It then reads every page back and compares it with the buffer. Finally it commits the image with a program-done command and triggers a refresh, which it checks through the target's status word and retries a limited number of times.

Every command is framed as one transaction: an opcode byte, three operand bytes sent most significant first, then an optional payload or read-back phase. The serial transport is hidden behind a valid/ready byte handshake for sending and a request/valid handshake for receiving. The flow waits for the target by polling its busy flag with a gap between polls, never with a fixed delay. A poll limit turns a target that stays busy into a failed run. The pass and fail outputs hold the result until the next start, and a step code shows the phase the flow is in.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset, busy, pass, fail, frame, tx_valid and rd_req are low and step reads 0 (idle).
- R2: A start pulse while idle or finished launches the flow, whose first command is 0xC6 with three zero operand bytes; every command is an opcode followed by three operand bytes, and a start pulse while busy has no effect on the command stream.
- R3: The erase command 0x0E is followed by busy polling; a poll is command 0xF0 with a one-byte reply whose bit 7 set means busy, each poll starts at least POLL_GAP cycles after the previous transaction ends, and polling repeats until bit 7 reads clear.
- R4: Before programming and again before read-back, command 0xB4 sets the address with operand bits 23:16 equal to 0x40 when mem_user is high and 0x00 otherwise, bits 15:14 zero and bits 13:0 equal to start_page.
- R5: For each of num_pages pages (num_pages at least 1), command 0x70 with zero operands is followed by exactly 16 payload bytes, buffer bytes 0 to 15 of that page, and then by busy polling.
- R6: Read-back issues per page command 0x73 with operand 0x000001 and reads 16 bytes; any byte that differs from the buffer ends the flow in fail after that page.
- R7: After read-back, command 0x5E is sent and followed by busy polling.
- R8: The refresh command 0x79 is followed by a wait of at least REFRESH_WAIT cycles and by command 0x3C, whose 4-byte reply forms a 32-bit status word most significant byte first; bit 8 set with bit 13 clear ends the flow in pass.
- R9: Any other status reply repeats the refresh and status pair; after REF_RETRIES repeats that still fail, the flow ends in fail.
- R10: If MAX_POLLS consecutive polls all read busy the flow ends in fail; a clear reply on the MAX_POLLS-th poll lets the flow continue.
- R11: busy is high from the cycle after start until the result; pass and fail are never high together and hold until the next start.
- R12: A byte is sent only in a cycle with tx_valid and tx_ready high, tx_valid and tx_data stay unchanged while tx_ready is low, a byte is received only with rd_req and rd_valid high, and frame is high through each whole command and low for at least one cycle between commands.
- R13: step reads 1 while entering offline mode, 11 after pass and 12 after fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the flow when not busy |
| mem_user | input | 1 | Selects the user flash area in the address operand |
| start_page | input | 14 | First page number written and read |
| num_pages | input | PW | Number of pages to write |
| tx_valid | output | 1 | Byte to send is present |
| tx_data | output | 8 | Byte to send |
| tx_ready | input | 1 | Channel accepts the byte this cycle |
| rd_req | output | 1 | A reply byte is wanted |
| rd_valid | input | 1 | Reply byte is present |
| rd_data | input | 8 | Reply byte |
| frame | output | 1 | High for the whole of one command transaction |
| buf_page | output | PW | Page index into the local buffer |
| buf_idx | output | 4 | Byte index into the buffer page |
| buf_data | input | 8 | Buffer byte at buf_page, buf_idx |
| busy | output | 1 | Flow in progress |
| pass | output | 1 | Flow ended successfully |
| fail | output | 1 | Flow ended in failure |
| step | output | 4 | Current phase code |

## Verification
The busy-clear reply and the poll limit can land on the same poll: the MAX_POLLS-th poll may be the one that reads clear, and then the counter that would end the run and the condition that lets it continue are decided in the same cycle. The bench provokes this by setting the target model to answer busy exactly MAX_POLLS-1 times after the erase and after program-done, and judges it by requiring a pass with exactly MAX_POLLS polls in the logged command stream. One poll more of busy must instead give a fail with the stream cut off at the last poll.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_ENTER   = 4'd1,
    ST_ERASE   = 4'd2,
    ST_SETADR  = 4'd3,
    ST_WRPAGE  = 4'd4,
    ST_VSETADR = 4'd5,
    ST_RDPAGE  = 4'd6,
    ST_COMMIT  = 4'd7,
    ST_RELOAD  = 4'd8,
    ST_RLWAIT  = 4'd9,
    ST_RLSTAT  = 4'd10,
    ST_PASS    = 4'd11,
    ST_FAIL    = 4'd12,
    ST_GAP     = 4'd13,
    ST_POLL    = 4'd14
  } step_t;

  localparam logic [7:0] OP_ENTER  = 8'hC6;
  localparam logic [7:0] OP_ERASE  = 8'h0E;
  localparam logic [7:0] OP_SETADR = 8'hB4;
  localparam logic [7:0] OP_WRPAGE = 8'h70;
  localparam logic [7:0] OP_RDPAGE = 8'h73;
  localparam logic [7:0] OP_COMMIT = 8'h5E;
  localparam logic [7:0] OP_RELOAD = 8'h79;
  localparam logic [7:0] OP_STATUS = 8'h3C;
  localparam logic [7:0] OP_POLL   = 8'hF0;

  localparam int          PAGE_BYTES = 16;
  localparam int          CW         = 5;
  localparam logic [31:0] MASK_BUSY  = 32'h0000_0080;
  localparam logic [31:0] MASK_STAT  = 32'h0000_2100;
  localparam logic [31:0] STAT_OK    = 32'h0000_0100;
endpackage

// File: rtl/fsq_timer.sv
module fsq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/fsq_xfer.sv
module fsq_xfer
  import fsq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    op,
  input  logic [23:0]   opnd,
  input  logic [CW-1:0] n_pay,
  input  logic [CW-1:0] n_rd,
  input  logic [7:0]    pay_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic          rd_req,
  input  logic          rd_valid,
  input  logic [7:0]    rd_data,
  output logic          frame,
  output logic [3:0]    idx,
  output logic          rd_stb,
  output logic          done,
  output logic [31:0]   rx_word
);
  typedef enum logic [1:0] {X_IDLE, X_HDR, X_PAY, X_RD} xst_t;

  xst_t          st_q, st_d;
  logic [31:0]   hdr_q, hdr_d, rx_q, rx_d;
  logic [CW-1:0] cnt_q, cnt_d, npay_q, npay_d, nrd_q, nrd_d;
  logic          fin;
  logic          done_q;

  always_comb begin
    st_d = st_q; hdr_d = hdr_q; rx_d = rx_q; cnt_d = cnt_q;
    npay_d = npay_q; nrd_d = nrd_q; fin = 1'b0;
    case (st_q)
      X_IDLE: if (start) begin
        hdr_d = {op, opnd}; cnt_d = '0; npay_d = n_pay; nrd_d = n_rd;
        st_d = X_HDR;
      end
      X_HDR: if (tx_ready) begin
        hdr_d = {hdr_q[23:0], 8'h00};
        if (cnt_q == CW'(3)) begin
          cnt_d = '0;
          if (npay_q != '0)     st_d = X_PAY;
          else if (nrd_q != '0) st_d = X_RD;
          else begin st_d = X_IDLE; fin = 1'b1; end
        end else cnt_d = cnt_q + 1'b1;
      end
      X_PAY: if (tx_ready) begin
        if (cnt_q == npay_q - 1'b1) begin
          cnt_d = '0;
          if (nrd_q != '0) st_d = X_RD;
          else begin st_d = X_IDLE; fin = 1'b1; end
        end else cnt_d = cnt_q + 1'b1;
      end
      X_RD: if (rd_valid) begin
        rx_d = {rx_q[23:0], rd_data};
        if (cnt_q == nrd_q - 1'b1) begin
          cnt_d = '0; st_d = X_IDLE; fin = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = X_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= X_IDLE; hdr_q <= '0; rx_q <= '0; cnt_q <= '0;
      npay_q <= '0; nrd_q <= '0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; hdr_q <= hdr_d; rx_q <= rx_d; cnt_q <= cnt_d;
      npay_q <= npay_d; nrd_q <= nrd_d; done_q <= fin;
    end
  end

  assign tx_valid = (st_q == X_HDR) || (st_q == X_PAY);
  assign tx_data  = (st_q == X_HDR) ? hdr_q[31:24] : pay_data;
  assign rd_req   = (st_q == X_RD);
  assign rd_stb   = (st_q == X_RD) && rd_valid;
  assign frame    = (st_q != X_IDLE);
  assign idx      = cnt_q[3:0];
  assign done     = done_q;
  assign rx_word  = rx_q;
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import fsq_pkg::*;
#(
  parameter int PW           = 4,
  parameter int POLL_GAP     = 8,
  parameter int REFRESH_WAIT = 20,
  parameter int MAX_POLLS    = 6,
  parameter int REF_RETRIES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mem_user,
  input  logic [13:0]   start_page,
  input  logic [PW-1:0] num_pages,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  input  logic          tx_ready,
  output logic          rd_req,
  input  logic          rd_valid,
  input  logic [7:0]    rd_data,
  output logic          frame,
  output logic [PW-1:0] buf_page,
  output logic [3:0]    buf_idx,
  input  logic [7:0]    buf_data,
  output logic          busy,
  output logic          pass,
  output logic          fail,
  output logic [3:0]    step
);
  localparam int WMAX = (POLL_GAP > REFRESH_WAIT) ? POLL_GAP : REFRESH_WAIT;
  localparam int TW   = $clog2(WMAX + 1);
  localparam int PCW  = $clog2(MAX_POLLS + 2);
  localparam int RCW  = $clog2(REF_RETRIES + 2);

  step_t          state_q, state_d, ret_q, ret_d;
  logic           launched_q, launched_d, mism_q, mism_d, user_q, user_d;
  logic [PW-1:0]  page_q, page_d, npages_q, npages_d;
  logic [13:0]    spage_q, spage_d;
  logic [PCW-1:0] polls_q, polls_d;
  logic [RCW-1:0] tries_q, tries_d;

  logic           xstart, xdone, xstb, tload, tzero, cmd_state, last_page;
  logic [7:0]     x_op;
  logic [23:0]    x_opnd, adr_opnd;
  logic [CW-1:0]  x_npay, x_nrd;
  logic [31:0]    x_rx;
  logic [TW-1:0]  tval;
  logic [3:0]     x_idx;
  logic           rx_busy, rx_ok;

  fsq_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .start(xstart), .op(x_op), .opnd(x_opnd),
    .n_pay(x_npay), .n_rd(x_nrd), .pay_data(buf_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .frame(frame), .idx(x_idx), .rd_stb(xstb), .done(xdone), .rx_word(x_rx)
  );

  fsq_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .val(tval), .zero(tzero)
  );

  assign rx_busy   = (x_rx & MASK_BUSY) != '0;
  assign rx_ok     = (x_rx & MASK_STAT) == STAT_OK;
  assign last_page = (page_q == npages_q - 1'b1);
  assign adr_opnd  = {(user_q ? 8'h40 : 8'h00), 2'b00, spage_q};

  // Command mux: one opcode, operand and length set per command step
  always_comb begin
    x_op = 8'h00; x_opnd = '0; x_npay = '0; x_nrd = '0; cmd_state = 1'b1;
    case (state_q)
      ST_ENTER:   x_op = OP_ENTER;
      ST_ERASE:   x_op = OP_ERASE;
      ST_SETADR,
      ST_VSETADR: begin x_op = OP_SETADR; x_opnd = adr_opnd; end
      ST_WRPAGE:  begin x_op = OP_WRPAGE; x_npay = CW'(PAGE_BYTES); end
      ST_RDPAGE:  begin x_op = OP_RDPAGE; x_opnd = 24'h000001; x_nrd = CW'(PAGE_BYTES); end
      ST_COMMIT:  x_op = OP_COMMIT;
      ST_RELOAD:  x_op = OP_RELOAD;
      ST_RLSTAT:  begin x_op = OP_STATUS; x_nrd = CW'(4); end
      ST_POLL:    begin x_op = OP_POLL; x_nrd = CW'(1); end
      default:    cmd_state = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q; ret_d = ret_q; launched_d = launched_q; mism_d = mism_q;
    page_d = page_q; npages_d = npages_q; spage_d = spage_q; user_d = user_q;
    polls_d = polls_q; tries_d = tries_q;
    xstart = 1'b0; tload = 1'b0; tval = TW'(POLL_GAP);

    if (cmd_state && !launched_q) begin
      xstart = 1'b1; launched_d = 1'b1;
    end
    if (xdone) launched_d = 1'b0;
    if (state_q == ST_RDPAGE && xstb && rd_data != buf_data) mism_d = 1'b1;

    case (state_q)
      ST_IDLE, ST_PASS, ST_FAIL: if (start) begin
        npages_d = num_pages; spage_d = start_page; user_d = mem_user;
        state_d = ST_ENTER;
      end
      ST_ENTER:  if (xdone) state_d = ST_ERASE;
      ST_ERASE:  if (xdone) begin
        ret_d = ST_SETADR; polls_d = '0; tload = 1'b1; state_d = ST_GAP;
      end
      ST_SETADR: if (xdone) begin page_d = '0; state_d = ST_WRPAGE; end
      ST_WRPAGE: if (xdone) begin
        ret_d = last_page ? ST_VSETADR : ST_WRPAGE;
        page_d = page_q + 1'b1; polls_d = '0; tload = 1'b1; state_d = ST_GAP;
      end
      ST_VSETADR: if (xdone) begin
        page_d = '0; mism_d = 1'b0; state_d = ST_RDPAGE;
      end
      ST_RDPAGE: if (xdone) begin
        if (mism_q)         state_d = ST_FAIL;
        else if (last_page) state_d = ST_COMMIT;
        else                page_d  = page_q + 1'b1;
      end
      ST_COMMIT: if (xdone) begin
        ret_d = ST_RELOAD; tries_d = '0; polls_d = '0; tload = 1'b1; state_d = ST_GAP;
      end
      ST_RELOAD: if (xdone) begin
        tval = TW'(REFRESH_WAIT); tload = 1'b1; state_d = ST_RLWAIT;
      end
      ST_RLWAIT: if (tzero) state_d = ST_RLSTAT;
      ST_RLSTAT: if (xdone) begin
        if (rx_ok)                              state_d = ST_PASS;
        else if (tries_q == RCW'(REF_RETRIES))  state_d = ST_FAIL;
        else begin tries_d = tries_q + 1'b1;    state_d = ST_RELOAD; end
      end
      ST_GAP:  if (tzero) state_d = ST_POLL;
      ST_POLL: if (xdone) begin
        if (!rx_busy) begin polls_d = '0; state_d = ret_q; end
        else if (polls_q == PCW'(MAX_POLLS - 1)) state_d = ST_FAIL;
        else begin
          polls_d = polls_q + 1'b1; tload = 1'b1; state_d = ST_GAP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; ret_q <= ST_IDLE; launched_q <= 1'b0; mism_q <= 1'b0;
      page_q <= '0; npages_q <= '0; spage_q <= '0; user_q <= 1'b0;
      polls_q <= '0; tries_q <= '0;
    end else begin
      state_q <= state_d; ret_q <= ret_d; launched_q <= launched_d; mism_q <= mism_d;
      page_q <= page_d; npages_q <= npages_d; spage_q <= spage_d; user_q <= user_d;
      polls_q <= polls_d; tries_q <= tries_d;
    end
  end

  assign buf_page = page_q;
  assign buf_idx  = x_idx;
  assign pass     = (state_q == ST_PASS);
  assign fail     = (state_q == ST_FAIL);
  assign busy     = !(state_q == ST_IDLE || pass || fail);
  assign step     = state_q;
endmodule

// File: rtl/fsq_chk.sv
module fsq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       rd_req,
  input logic       rd_valid,
  input logic       frame,
  input logic       busy,
  input logic       pass,
  input logic       fail,
  input logic [3:0] step
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd0) |-> (!tx_valid && !rd_req && !frame && !busy)); // R1

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R12

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> rd_req); // R12

  AST_TX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || rd_req) |-> frame); // R12

  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rd_req)); // R12

  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail) && !(busy && (pass || fail))); // R11

  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && !start) |=> pass); // R11

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail); // R11

  AST_START_GOES: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && step == 4'd1)); // R2
endmodule

bind flash_seq_ctrl fsq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_ready(tx_ready), .rd_req(rd_req),
  .rd_valid(rd_valid), .frame(frame), .busy(busy), .pass(pass),
  .fail(fail), .step(step)
);

// File: tb/flash_seq_ctrl_tb.sv
module flash_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4, GAP = 8, RWAIT = 20, MAXP = 6, RETR = 2;
  localparam int NV = 7;
  // fields: pages[47:44] erase_busy[43:40] prog_busy[39:36] done_busy[35:32]
  // refresh_fails[31:28] corrupt[27] stall[26] user[25] exp_pass[24] spage[13:0]
  localparam logic [47:0] VEC [NV] = '{
    {4'd1, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 10'd0, 14'd5},
    {4'd3, 4'd2, 4'd1, 4'd1, 4'd1, 1'b0, 1'b1, 1'b1, 1'b1, 10'd0, 14'h3FF0},
    {4'd2, 4'd5, 4'd0, 4'd5, 4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 10'd0, 14'd7},
    {4'd1, 4'd6, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 10'd0, 14'd2},
    {4'd2, 4'd0, 4'd0, 4'd0, 4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0, 14'd9},
    {4'd2, 4'd0, 4'd1, 4'd0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 10'd0, 14'd4},
    {4'd4, 4'd0, 4'd6, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 10'd0, 14'd1}
  };

  logic clk, rst_n, start, mem_user;
  logic [13:0] start_page;
  logic [PW-1:0] num_pages, buf_page;
  logic tx_valid, tx_ready, rd_req, rd_valid, frame, busy, pass, fail;
  logic [7:0] tx_data, rd_data, buf_data;
  logic [3:0] buf_idx, step;

  flash_seq_ctrl #(.PW(PW), .POLL_GAP(GAP), .REFRESH_WAIT(RWAIT),
                   .MAX_POLLS(MAXP), .REF_RETRIES(RETR)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_user(mem_user),
    .start_page(start_page), .num_pages(num_pages), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_data(rd_data), .frame(frame), .buf_page(buf_page), .buf_idx(buf_idx),
    .buf_data(buf_data), .busy(busy), .pass(pass), .fail(fail), .step(step)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  // model configuration (written by tasks only)
  int cfg_eb, cfg_pb, cfg_db, cfg_rf, clr_req = 0;
  bit cfg_corrupt, cfg_stall;
  logic [7:0] seed;
  // model state (written by the model only)
  int clr_seen = 0, busy_left, ref_n, nb, rdn, gap, last_end, n_log;
  int op_err, len_err, gap_err, rgap_err;
  bit in_frame, first_wr, ref_ok;
  logic [13:0] ptr;
  logic [7:0] fb [24];
  logic [7:0] fmem [16][16];
  logic [7:0] log_ops [256];
  logic [23:0] exp_adr;
  logic [31:0] sword;

  function automatic logic [7:0] pat(input logic [PW-1:0] p, input logic [3:0] i, input logic [7:0] s);
    return {p, i} ^ s;
  endfunction
  assign buf_data = pat(buf_page, buf_idx, seed);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Target model: acts at the falling edge on what the DUT presents
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
    if (clr_req != clr_seen) begin
      clr_seen = clr_req; busy_left = 0; ref_n = 0; ref_ok = 0; n_log = 0;
      op_err = 0; len_err = 0; gap_err = 0; rgap_err = 0; first_wr = 1;
      in_frame = 0; last_end = cyc; ptr = '0;
      for (int a = 0; a < 16; a++) for (int b = 0; b < 16; b++) fmem[a][b] = 8'h00;
    end
    tx_ready = cfg_stall ? (cyc % 3 != 0) : 1'b1;
    rd_valid = cfg_stall ? (cyc % 4 != 1) : 1'b1;
    if (frame && !in_frame) begin
      in_frame = 1; nb = 0; rdn = 0; gap = cyc - last_end;
    end
    if (tx_valid && tx_ready && nb < 24) begin fb[nb] = tx_data; nb++; end
    if (rd_req && rd_valid) begin
      case (fb[0])
        8'hF0: rd_data = (busy_left > 0) ? 8'h80 : 8'h00;
        8'h3C: begin sword = ref_ok ? 32'h0000_0100 : 32'h0000_2000;
                 rd_data = sword[31 - 8*rdn -: 8]; end
        8'h73: rd_data = fmem[ptr[3:0]][rdn[3:0]];
        default: rd_data = 8'hEE;
      endcase
      rdn++;
    end
    if (!frame && in_frame) begin
      in_frame = 0; last_end = cyc;
      if (n_log < 256) begin log_ops[n_log] = fb[0]; n_log++; end
      if (nb != ((fb[0] == 8'h70) ? 20 : 4)) len_err++;
      case (fb[0])
        8'h0E: begin
          for (int a = 0; a < 16; a++) for (int b = 0; b < 16; b++) fmem[a][b] = 8'hFF;
          busy_left = cfg_eb;
        end
        8'hB4: begin if ({fb[1], fb[2], fb[3]} != exp_adr) op_err++; ptr = {fb[2][5:0], fb[3]}; end
        8'h70: begin
          if ({fb[1], fb[2], fb[3]} != 24'h0) op_err++;
          for (int b = 0; b < 16; b++) fmem[ptr[3:0]][b] = fb[4+b];
          if (first_wr && cfg_corrupt) fmem[ptr[3:0]][5] = ~fb[9];
          first_wr = 0; ptr++; busy_left = cfg_pb;
        end
        8'h73: begin if ({fb[1], fb[2], fb[3]} != 24'h000001) op_err++; ptr++; end
        8'h5E: busy_left = cfg_db;
        8'h79: begin ref_n++; ref_ok = (ref_n > cfg_rf); end
        8'h3C: if (gap < RWAIT) rgap_err++;
        8'hF0: begin if (gap < GAP) gap_err++; if (busy_left > 0) busy_left--; end
        default: if ({fb[1], fb[2], fb[3]} != 24'h0) op_err++;
      endcase
    end
  end

  logic [7:0] exp_ops [256];
  int n_exp;
  bit exp_ok;

  task automatic push(input logic [7:0] o);
    exp_ops[n_exp] = o; n_exp++;
  endtask

  // returns 0 when the poll limit ends the flow
  function automatic bit polls_ok(input int b);
    return b < MAXP;
  endfunction

  task automatic build_exp(input logic [47:0] v);
    int np, np_polls;
    bit alive;
    n_exp = 0; alive = 1; np = int'(v[47:44]);
    push(8'hC6); push(8'h0E);
    np_polls = polls_ok(int'(v[43:40])) ? int'(v[43:40]) + 1 : MAXP;
    for (int k = 0; k < np_polls; k++) push(8'hF0);
    alive = polls_ok(int'(v[43:40]));
    if (alive) begin
      push(8'hB4);
      for (int p = 0; p < np && alive; p++) begin
        push(8'h70);
        np_polls = polls_ok(int'(v[39:36])) ? int'(v[39:36]) + 1 : MAXP;
        for (int k = 0; k < np_polls; k++) push(8'hF0);
        alive = polls_ok(int'(v[39:36]));
      end
    end
    if (alive) begin
      push(8'hB4);
      for (int p = 0; p < np && alive; p++) begin
        push(8'h73);
        if (v[27]) alive = 0;
      end
    end
    if (alive) begin
      push(8'h5E);
      np_polls = polls_ok(int'(v[35:32])) ? int'(v[35:32]) + 1 : MAXP;
      for (int k = 0; k < np_polls; k++) push(8'hF0);
      alive = polls_ok(int'(v[35:32]));
    end
    if (alive) begin
      for (int a = 0; a <= RETR; a++) begin
        if (a > 0 && a > int'(v[31:28])) break;
        push(8'h79); push(8'h3C);
      end
      alive = (int'(v[31:28]) <= RETR);
    end
    exp_ok = alive;
  endtask

  task automatic run_vec(input logic [47:0] v, input bit mid_start, input string req);
    int t;
    bit seq_ok;
    cfg_eb = int'(v[43:40]); cfg_pb = int'(v[39:36]); cfg_db = int'(v[35:32]);
    cfg_rf = int'(v[31:28]); cfg_corrupt = v[27]; cfg_stall = v[26];
    seed = v[7:0] ^ 8'h3C;
    @(negedge clk);
    mem_user = v[25]; start_page = v[13:0]; num_pages = v[47:44];
    exp_adr = {(v[25] ? 8'h40 : 8'h00), 2'b00, v[13:0]};
    clr_req++;
    build_exp(v);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(step == 4'd1 && busy, "R13 step entering offline", step, 1);
    t = 0;
    while (!(pass || fail) && t < 20000) begin
      @(negedge clk); t++;
      if (mid_start && t == 40) start = 1'b1;
      if (mid_start && t == 41) start = 1'b0;
    end
    check(pass == v[24] && fail == !v[24], {req, " result"}, {pass, fail}, {v[24], !v[24]});
    check(step == (v[24] ? 4'd11 : 4'd12), "R13 final step", step, v[24] ? 11 : 12);
    seq_ok = (n_log == n_exp);
    for (int k = 0; k < n_exp && k < n_log; k++) if (log_ops[k] != exp_ops[k]) seq_ok = 0;
    check(seq_ok, {req, " R2 R7 command order"}, n_log, n_exp);
    check(op_err == 0, "R4 operand fields", op_err, 0);
    check(len_err == 0, "R5 frame length", len_err, 0);
    check(gap_err == 0, "R3 poll gap", gap_err, 0);
    check(rgap_err == 0, "R8 refresh wait", rgap_err, 0);
    if (v[24]) begin
      int bad = 0;
      for (int p = 0; p < int'(v[47:44]); p++)
        for (int b = 0; b < 16; b++)
          if (fmem[(v[3:0] + p) % 16][b] != pat(PW'(p), 4'(b), seed)) bad++;
      check(bad == 0, "R5 R12 flash content", bad, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mem_user = 1'b0; start_page = '0; num_pages = '0;
    cfg_eb = 0; cfg_pb = 0; cfg_db = 0; cfg_rf = 0; cfg_corrupt = 0; cfg_stall = 0;
    seed = 8'h00; exp_adr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !pass && !fail && !frame && !tx_valid && !rd_req && step == 4'd0,
          "R1 reset state", {busy, pass, fail, frame, tx_valid, rd_req}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && step == 4'd0, "R1 idle after release", step, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0, $sformatf("vec%0d R8 R9 R10 R6", i));

    // R2: start while busy must not disturb the command stream
    run_vec(VEC[0], 1'b1, "R2 start while busy");

    // R11: result held without a new start
    repeat (60) @(negedge clk);
    check(pass && !fail && !busy && step == 4'd11, "R11 pass held", {pass, fail}, 2'b10);
    run_vec(VEC[3], 1'b0, "R10 timeout again");
    repeat (60) @(negedge clk);
    check(fail && !pass && step == 4'd12, "R11 fail held", {pass, fail}, 2'b01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule